// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits beside a transmit path and stops a station that never stops sending. It counts how many clock cycles in a row the synchronous `txActive` indication stays high. With the default limits it runs from a 10 MHz clock, so each cycle is 100 ns. When a burst goes on past the legal limit, the block enters a fault. During the fault it drops `txEnable` so the line driver stops passing data, and it raises `jabberFault` so the station sees a collision-style indication.

The fault ends when activity stops. The block then moves to a recovery phase, which it reports on `unjabPending`. Transmission is allowed again only after a long unbroken quiet interval. Any activity during recovery starts that interval over. Both limits are parameters. The defaults are 200,000 cycles (20 ms) for the burst limit and 5,000,000 cycles (500 ms) for the quiet interval, and simulation can use small values. `txActive` must already be squelched and synchronous to `clk`. `QUIET_CYCLES` must be at least 2.

Top module: `jabber_guard`

## Requirements
- R1: With `rst` high at a rising edge, the outputs after that edge are `txEnable`=1, `jabberFault`=0 and `unjabPending`=0, and both counters are cleared. This also applies in the middle of a fault or a recovery.
- R2: A burst of at most `TRIP_CYCLES` consecutive high samples of `txActive` leaves `txEnable` high and `jabberFault` low.
- R3: A single low sample of `txActive` clears the activity count. Bursts of `TRIP_CYCLES` separated by one low cycle therefore never cause a fault.
- R4: On the edge that samples the (`TRIP_CYCLES`+1)-th consecutive high `txActive`, the block enters the fault: `txEnable` goes to 0 and `jabberFault` goes to 1.
- R5: While in the fault and while `txActive` stays high, `jabberFault` stays 1 and `txEnable` stays 0.
- R6: The first low sample of `txActive` in the fault ends it: `jabberFault` goes to 0, `unjabPending` goes to 1 and `txEnable` stays 0.
- R7: `txEnable` returns to 1, and `unjabPending` goes to 0, on the edge that samples the `QUIET_CYCLES`-th consecutive low `txActive`. The sample that ended the fault counts as the first. No earlier edge re-enables transmission.
- R8: A high sample of `txActive` during recovery restarts the quiet count and keeps `unjabPending` at 1. However long that activity lasts, it raises no new fault.
- R9: At every moment exactly one of `txEnable`, `jabberFault` and `unjabPending` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (10 MHz by default) |
| rst | input | 1 | Synchronous reset, active high |
| txActive | input | 1 | Squelched, synchronous transmit-activity indication |
| txEnable | output | 1 | High when transmit data may pass to the line driver |
| jabberFault | output | 1 | Collision/jabber indication, high for the whole fault |
| unjabPending | output | 1 | High while the quiet recovery interval is running |

## Verification
The assertions assume that `txActive` and `rst` are synchronous, meaning they change only between rising edges and are stable at each edge. They also assume that `QUIET_CYCLES` is at least 2, so that the sample ending a fault can count as the first quiet cycle. The bench drives every input on the falling edge and runs with small limits. This lets it reach the exact boundaries: bursts one cycle short of the limit and one cycle past it, re-activation partway through recovery, and a reset taken in the middle of a fault.

// File: rtl/jabber_pkg.sv
`timescale 1ns/1ps
package jabber_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_FAULT   = 2'd1,
    ST_RECOVER = 2'd2
  } guardState_t;

  typedef struct packed {
    logic runInc;
    logic runClr;
    logic quietInc;
    logic quietClr;
  } guardStrobe_t;

endpackage

// File: rtl/jabber_datapath.sv
`timescale 1ns/1ps
module jabber_datapath
  import jabber_pkg::*;
#(
  parameter int TRIP_CYCLES  = 200000,
  parameter int QUIET_CYCLES = 5000000
) (
  input  logic         clk,
  input  logic         rst,
  input  guardStrobe_t strobe,
  output logic         runAtLimit,
  output logic         quietDone
);

  localparam int RUN_W   = $clog2(TRIP_CYCLES + 1);
  localparam int QUIET_W = $clog2(QUIET_CYCLES);

  logic [RUN_W-1:0]   runCount;
  logic [QUIET_W-1:0] quietCount;

  always_ff @(posedge clk) begin
    if (rst || strobe.runClr) begin
      runCount <= '0;
    end else if (strobe.runInc) begin
      runCount <= runCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.quietClr) begin
      quietCount <= '0;
    end else if (strobe.quietInc) begin
      quietCount <= quietCount + 1'b1;
    end
  end

  assign runAtLimit = (runCount == RUN_W'(TRIP_CYCLES));
  assign quietDone  = (quietCount == QUIET_W'(QUIET_CYCLES - 1));

  // R2: the activity count never runs past the trip limit
  a_r2_run_bound: assert property (@(posedge clk) disable iff (rst)
    runCount <= RUN_W'(TRIP_CYCLES));

  // R7: the quiet count never passes its terminal value
  a_r7_quiet_bound: assert property (@(posedge clk) disable iff (rst)
    quietCount <= QUIET_W'(QUIET_CYCLES - 1));

endmodule

// File: rtl/jabber_control.sv
`timescale 1ns/1ps
module jabber_control
  import jabber_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         txActive,
  input  logic         runAtLimit,
  input  logic         quietDone,
  output guardStrobe_t strobe,
  output logic         txEnable,
  output logic         jabberFault,
  output logic         unjabPending
);

  guardState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_NORMAL: begin
        if (txActive) begin
          if (runAtLimit) begin
            stateNext     = ST_FAULT;
            strobe.runClr = 1'b1;
          end else begin
            strobe.runInc = 1'b1;
          end
        end else begin
          strobe.runClr = 1'b1;
        end
      end
      ST_FAULT: begin
        if (txActive) begin
          strobe.quietClr = 1'b1;
        end else begin
          stateNext       = ST_RECOVER;
          strobe.quietInc = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (txActive) begin
          strobe.quietClr = 1'b1;
        end else if (quietDone) begin
          stateNext       = ST_NORMAL;
          strobe.quietClr = 1'b1;
        end else begin
          strobe.quietInc = 1'b1;
        end
      end
      default: stateNext = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_NORMAL;
    else     state <= stateNext;
  end

  assign txEnable     = (state == ST_NORMAL);
  assign jabberFault  = (state == ST_FAULT);
  assign unjabPending = (state == ST_RECOVER);

  // R3: a quiet cycle while enabled keeps transmission enabled
  a_r3_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (txEnable && !txActive) |=> txEnable);

  // R4: activity at the limit trips the fault
  a_r4_trip: assert property (@(posedge clk) disable iff (rst)
    (txEnable && txActive && runAtLimit) |=> jabberFault);

  // R5: the fault persists while activity persists
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (jabberFault && txActive) |=> (jabberFault && !txEnable));

  // R6: activity stopping moves the fault into recovery
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (jabberFault && !txActive) |=> (unjabPending && !jabberFault));

  // R7: recovery does not end before the quiet count is done
  a_r7_no_early: assert property (@(posedge clk) disable iff (rst)
    (unjabPending && !txActive && !quietDone) |=> unjabPending);

  // R8: activity during recovery keeps the block recovering
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    (unjabPending && txActive) |=> (unjabPending && !txEnable));

  // R9: exactly one status output is high
  a_r9_one_hot: assert property (@(posedge clk) disable iff (rst)
    $countones({txEnable, jabberFault, unjabPending}) == 1);

endmodule

// File: rtl/jabber_guard.sv
`timescale 1ns/1ps
module jabber_guard
  import jabber_pkg::*;
#(
  parameter int TRIP_CYCLES  = 200000,
  parameter int QUIET_CYCLES = 5000000
) (
  input  logic clk,
  input  logic rst,
  input  logic txActive,
  output logic txEnable,
  output logic jabberFault,
  output logic unjabPending
);

  guardStrobe_t strobe;
  logic         runAtLimit;
  logic         quietDone;

  jabber_control u_control (
    .clk          (clk),
    .rst          (rst),
    .txActive     (txActive),
    .runAtLimit   (runAtLimit),
    .quietDone    (quietDone),
    .strobe       (strobe),
    .txEnable     (txEnable),
    .jabberFault  (jabberFault),
    .unjabPending (unjabPending)
  );

  jabber_datapath #(
    .TRIP_CYCLES  (TRIP_CYCLES),
    .QUIET_CYCLES (QUIET_CYCLES)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .runAtLimit (runAtLimit),
    .quietDone  (quietDone)
  );

endmodule

// File: tb/jabber_guard_test.sv
`timescale 1ns/1ps
module jabber_guard_test;

  localparam int CLK_PERIOD = 100;
  localparam int TRIP  = 8;
  localparam int QUIET = 12;

  typedef struct {
    logic [2:0] expOut;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txActive = 1'b0;
  logic txEnable, jabberFault, unjabPending;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  expItem_t expQ[$];

  // reference model state, from the requirements
  int mState = 0;   // 0 normal, 1 fault, 2 recovering
  int mRun = 0;
  int mQuiet = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jabber_guard #(.TRIP_CYCLES(TRIP), .QUIET_CYCLES(QUIET)) uut (
    .clk          (clk),
    .rst          (rst),
    .txActive     (txActive),
    .txEnable     (txEnable),
    .jabberFault  (jabberFault),
    .unjabPending (unjabPending)
  );

  task automatic step(input logic act, input logic rs, input string tag);
    expItem_t it;
    @(negedge clk);
    txActive = act;
    rst = rs;
    if (rs) begin
      mState = 0; mRun = 0; mQuiet = 0;
    end else begin
      case (mState)
        0: if (act) begin
             if (mRun == TRIP) begin mState = 1; mRun = 0; end
             else mRun++;
           end else mRun = 0;
        1: if (!act) begin mState = 2; mQuiet = 1; end
        default: if (act) mQuiet = 0;
                 else if (mQuiet == QUIET - 1) begin mState = 0; mQuiet = 0; end
                 else mQuiet++;
      endcase
    end
    it.expOut = {mState == 0, mState == 1, mState == 2};
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic run(input logic act, input int n, input string tag);
    for (int i = 0; i < n; i++) step(act, 1'b0, tag);
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        logic [2:0] act;
        e = expQ.pop_front();
        act = {txEnable, jabberFault, unjabPending};
        vectors++;
        if (act !== e.expOut) begin
          miscompares++;
          $display("FAIL %s: {txEnable,jabberFault,unjabPending} got %b expected %b at %0t",
                   e.tag, act, e.expOut, $time);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    step(1'b0, 1'b1, "R1 reset");
    step(1'b0, 1'b1, "R1 reset");
    run(1'b0, 3, "R1 idle after reset");
    run(1'b1, TRIP, "R2 burst at limit");
    run(1'b0, 1, "R3 gap");
    run(1'b1, TRIP, "R3 second burst");
    run(1'b0, 1, "R3 gap");
    run(1'b1, 5, "R2 short burst");
    run(1'b0, 2, "R3 idle");
    run(1'b1, TRIP + 1, "R4 trip");
    run(1'b1, 10, "R5 fault held");
    run(1'b0, 1, "R6 release");
    run(1'b0, 4, "R7 quiet partial");
    run(1'b1, 3, "R8 reactivation");
    run(1'b0, QUIET + 3, "R7 quiet full");
    run(1'b1, TRIP + 1, "R4 trip again");
    run(1'b0, 1, "R6 release");
    run(1'b1, 3 * TRIP, "R8 long activity in recovery");
    run(1'b0, QUIET - 1, "R7 one short of quiet");
    run(1'b0, 2, "R7 quiet reached");
    run(1'b1, TRIP + 3, "R4 trip for reset");
    step(1'b1, 1'b1, "R1 reset in fault");
    run(1'b0, 2, "R1 idle after reset");
    run(1'b1, TRIP + 1, "R4 trip");
    run(1'b0, 3, "R6 recovering");
    step(1'b0, 1'b1, "R1 reset in recovery");
    run(1'b0, 3, "R9 idle");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule